// File: doc/BRIEF.md
# Sixteen-State Hard-Decision Trellis Decoder

This block recovers the protected bits of a speech frame that was sent through a
rate-1/2, constraint-length-5 convolutional encoder. It takes one received code-bit
pair per accepted cycle and, after a full frame of 189 pairs, traces the most
likely path back from the all-zero end state. It then emits the 185 information
bits in transmit order, one per cycle. The four flushing bits that close the
trellis are consumed but never emitted.

Inside, a branch metric unit scores each received pair against the four possible
code pairs by Hamming distance. An array of 16 add-compare-select cells then updates
the path metrics and rescales them so that the smallest one is zero. One survivor
decision bit per state and step is stored for the whole frame. While the traceback
and the output run, the decoder refuses new input. It accepts the next frame again
in the cycle that carries the last decoded bit.

Top module: `vit16_dec`

## Requirements
- R1: Out of reset, in_ready is 1 and both out_valid and frame_done are 0.
- R2: A pair is taken on a rising clock edge when in_valid and in_ready are both 1. Cycles with in_valid at 0 leave the result unchanged. in_pair[0] is the first code bit, u(t)^u(t-1)^u(t-3)^u(t-4). in_pair[1] is the second code bit, u(t)^u(t-3)^u(t-4). The encoder starts in the zero state.
- R3: The path metrics are rescaled after every step so that at least one of them is zero. None of them ever reaches the top of its range.
- R4: After the 189th pair is taken, in_ready stays 0 until the last decoded bit. Pairs offered in that time have no effect on the output.
- R5: A frame received without errors decodes to exactly its 185 information bits, provided it was closed by 4 zero bits.
- R6: A frame in which single code bits are flipped at least 20 steps apart decodes to its original information bits.
- R7: Each frame yields exactly 185 output bits on consecutive cycles, information bit 0 first. The tail bits are never emitted.
- R8: The first out_valid of a frame goes high on the 190th rising edge after the edge that took the 189th pair.
- R9: frame_done is 1 only together with the 185th output bit of a frame. in_ready is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A code-bit pair is offered |
| in_pair | input | 2 | Received pair: bit 0 first code bit, bit 1 second |
| in_ready | output | 1 | Decoder is collecting pairs for the current frame |
| out_valid | output | 1 | out_bit carries a decoded information bit |
| out_bit | output | 1 | Decoded information bit, in transmit order |
| frame_done | output | 1 | Marks the last decoded bit of a frame |

## Verification
The checker assumes that in_valid is low while reset is applied. It also assumes the
upstream source never relies on a pair being taken while in_ready is low. The
stimulus meets both: it holds in_valid at 0 through reset and drives pairs only on
cycles where in_ready was seen high half a cycle earlier. The rescaling bound in the
checker holds for any bit pattern. The stimulus therefore also sends deliberately
meaningless pairs during the blocked phase, and it flips isolated code bits, so that
the metric range is exercised beyond clean frames.

// File: rtl/vit16_pkg.sv
package vit16_pkg;
    localparam int NST   = 16;
    localparam int ST_W  = 4;

    typedef enum logic [1:0] {PH_ACS, PH_TRACE, PH_EMIT} phase_t;

    // Code pair {second, first} produced when bit u enters with history s,
    // where s[0] is the newest past bit and s[3] the oldest.
    function automatic logic [1:0] code_pair(input logic [ST_W-1:0] s, input logic u);
        return {u ^ s[2] ^ s[3], u ^ s[0] ^ s[2] ^ s[3]};
    endfunction
endpackage

// File: rtl/vit16_bmu.sv
module vit16_bmu
    import vit16_pkg::*;
(
    input  logic [1:0]      rx,
    output logic [3:0][1:0] bm
);
    for (genvar c = 0; c < 4; c++) begin : g_code
        localparam logic [1:0] CV = 2'(c);
        logic [1:0] diff;
        assign diff  = rx ^ CV;
        assign bm[c] = {diff[0] & diff[1], diff[0] ^ diff[1]};
    end
endmodule

// File: rtl/vit16_acs.sv
module vit16_acs
    import vit16_pkg::*;
#(
    parameter int PM_W = 6
) (
    input  logic [NST-1:0][PM_W-1:0] pm_in,
    input  logic [3:0][1:0]          bm,
    output logic [NST-1:0][PM_W-1:0] pm_out,
    output logic [NST-1:0]           dec
);
    localparam int SW = PM_W + 1;

    logic [NST-1:0][SW-1:0] raw;
    logic [SW-1:0]          mn;

    for (genvar g = 0; g < NST; g++) begin : g_cell
        localparam logic [ST_W-1:0] NSV = ST_W'(g);
        localparam logic [ST_W-1:0] P0  = {1'b0, NSV[ST_W-1:1]};
        localparam logic [ST_W-1:0] P1  = {1'b1, NSV[ST_W-1:1]};
        localparam logic [1:0]      C0  = code_pair(P0, NSV[0]);
        localparam logic [1:0]      C1  = code_pair(P1, NSV[0]);
        logic [SW-1:0] m0, m1;
        assign m0     = {1'b0, pm_in[P0]} + SW'(bm[C0]);
        assign m1     = {1'b0, pm_in[P1]} + SW'(bm[C1]);
        // equal sums keep the lower-numbered predecessor
        assign dec[g] = (m1 < m0);
        assign raw[g] = dec[g] ? m1 : m0;
    end

    always_comb begin
        mn = raw[0];
        for (int i = 1; i < NST; i++) begin
            if (raw[i] < mn) mn = raw[i];
        end
        for (int i = 0; i < NST; i++) begin
            pm_out[i] = PM_W'(raw[i] - mn);
        end
    end
endmodule

// File: rtl/vit16_dec.sv
module vit16_dec
    import vit16_pkg::*;
#(
    parameter int N_INFO  = 185,
    parameter int N_TAIL  = 4,
    parameter int PM_W    = 6,
    parameter int PM_INIT = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] in_pair,
    output logic       in_ready,
    output logic       out_valid,
    output logic       out_bit,
    output logic       frame_done
);
    localparam int N_STEPS = N_INFO + N_TAIL;
    localparam int IDX_W   = $clog2(N_STEPS);

    typedef struct packed {
        phase_t                  ph;
        logic [IDX_W-1:0]        cnt;
        logic [NST-1:0][PM_W-1:0] pm;
        logic [ST_W-1:0]         tb;
        logic [N_STEPS-1:0]      bits;
        logic                    ovld;
        logic                    obit;
        logic                    done;
    } st_t;

    function automatic logic [NST-1:0][PM_W-1:0] pm_start();
        logic [NST-1:0][PM_W-1:0] v;
        for (int i = 0; i < NST; i++) v[i] = PM_W'(PM_INIT);
        v[0] = '0;
        return v;
    endfunction

    st_t st_d, st_q;

    logic [3:0][1:0]          bm;
    logic [NST-1:0][PM_W-1:0] acs_pm;
    logic [NST-1:0]           acs_dec;
    logic [NST-1:0]           surv_q [N_STEPS];
    logic [NST-1:0]           surv_rd;
    logic                     surv_we;
    logic [NST-1:0][PM_W-1:0] pm_cur;

    vit16_bmu u_bmu (
        .rx (in_pair),
        .bm (bm)
    );

    vit16_acs #(.PM_W(PM_W)) u_acs (
        .pm_in  (st_q.pm),
        .bm     (bm),
        .pm_out (acs_pm),
        .dec    (acs_dec)
    );

    assign surv_rd = surv_q[st_q.cnt];

    always_comb begin
        st_d      = st_q;
        st_d.ovld = 1'b0;
        st_d.done = 1'b0;
        surv_we   = 1'b0;
        unique case (st_q.ph)
            PH_ACS: begin
                if (in_valid) begin
                    st_d.pm = acs_pm;
                    surv_we = 1'b1;
                    if (st_q.cnt == IDX_W'(N_STEPS - 1)) begin
                        st_d.ph = PH_TRACE;
                        st_d.tb = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_TRACE: begin
                st_d.bits[st_q.cnt] = st_q.tb[0];
                st_d.tb = {surv_rd[st_q.tb], st_q.tb[ST_W-1:1]};
                if (st_q.cnt == '0) begin
                    st_d.ph = PH_EMIT;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_EMIT: begin
                st_d.ovld = 1'b1;
                st_d.obit = st_q.bits[st_q.cnt];
                if (st_q.cnt == IDX_W'(N_INFO - 1)) begin
                    st_d.done = 1'b1;
                    st_d.ph   = PH_ACS;
                    st_d.cnt  = '0;
                    st_d.pm   = pm_start();
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = PH_ACS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_ACS, cnt: '0, pm: pm_start(), tb: '0,
                      bits: '0, ovld: 1'b0, obit: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (surv_we) surv_q[st_q.cnt] <= acs_dec;
    end

    assign in_ready   = (st_q.ph == PH_ACS);
    assign out_valid  = st_q.ovld;
    assign out_bit    = st_q.obit;
    assign frame_done = st_q.done;
    assign pm_cur     = st_q.pm;
endmodule

// File: rtl/vit16_dec_chk.sv
module vit16_dec_chk
    import vit16_pkg::*;
#(
    parameter int PM_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic                     frame_done,
    input logic [NST-1:0][PM_W-1:0] pm
);
    localparam int PM_TOP = (1 << PM_W) - 3;

    function automatic logic any_zero(input logic [NST-1:0][PM_W-1:0] v);
        logic z = 1'b0;
        for (int i = 0; i < NST; i++) if (v[i] == '0) z = 1'b1;
        return z;
    endfunction

    function automatic logic all_below(input logic [NST-1:0][PM_W-1:0] v);
        logic ok = 1'b1;
        for (int i = 0; i < NST; i++) if (int'(v[i]) > PM_TOP) ok = 1'b0;
        return ok;
    endfunction

    // R1: output flags low while reset is held
    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (!out_valid && !frame_done);
        end
    end

    p_min_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_zero(pm));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        all_below(pm));

    p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !frame_done) |-> !in_ready);

    p_metrics_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !out_valid) |=> $stable(pm));

    p_done_with_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (out_valid && in_ready));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind vit16_dec vit16_dec_chk #(.PM_W(PM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .frame_done (frame_done),
    .pm         (pm_cur)
);

// File: tb/sim_vit16_dec.sv
`timescale 1ns/1ps
module sim_vit16_dec;
    localparam int N_INFO  = 185;
    localparam int N_STEPS = 189;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_pair = 2'b00;
    logic       in_ready, out_valid, out_bit, frame_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_q[$];
    int bit_idx = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    vit16_dec u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pair(in_pair),
        .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
        .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit next_rand();
        rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
        return rng[7];
    endfunction

    // Monitor: pops expected bits as the decoder emits them (R5 R6 R7 R9)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "bit with empty queue", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(out_bit == e, "R5 R6", "decoded bit", int'(out_bit), int'(e));
                end
                chk(frame_done == (bit_idx == N_INFO - 1), "R9", "frame_done position",
                    int'(frame_done), int'(bit_idx == N_INFO - 1));
                bit_idx = (bit_idx == N_INFO - 1) ? 0 : bit_idx + 1;
            end else if (rst_n) begin
                if (bit_idx != 0) chk(1'b0, "R7", "gap inside output burst", 0, 1);
                if (frame_done) chk(1'b0, "R9", "frame_done without bit", 1, 0);
            end
        end
    end

    task automatic send_pair(input logic [1:0] p, input int gap);
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_pair  = ~p;
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_pair  = p;
    endtask

    // mode: 0 zeros, 1 ones, 2 alternating, 3 pseudo-random
    task automatic run_frame(input int mode, input int err_every, input int gap_every,
                             input string tag);
        logic [3:0] s = 4'b0;
        int lat = 0;
        for (int t = 0; t < N_STEPS; t++) begin
            bit u;
            logic [1:0] p;
            if (t >= N_INFO) u = 1'b0;
            else case (mode)
                0: u = 1'b0;
                1: u = 1'b1;
                2: u = t[0];
                default: u = next_rand();
            endcase
            if (t < N_INFO) exp_q.push_back(u);
            p[0] = u ^ s[0] ^ s[2] ^ s[3];
            p[1] = u ^ s[2] ^ s[3];
            s = {s[2:0], u};
            if (err_every > 0 && (t % err_every) == 7) p[t % 2] = ~p[t % 2];
            send_pair(p, (gap_every > 0 && (t % gap_every) == 1) ? 2 : 0);
        end
        @(negedge clk);
        chk(in_ready == 1'b0, "R4", {tag, " ready after last pair"}, int'(in_ready), 0);
        // offer junk pairs while blocked (R4)
        in_valid = 1'b1;
        while (!out_valid && lat < 1000) begin
            @(negedge clk);
            in_pair = {next_rand(), next_rand()};
            lat++;
        end
        in_valid = 1'b0;
        chk(lat == 190, "R8", {tag, " latency to first bit"}, lat, 190);
        while (!frame_done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        chk(in_ready == 1'b1, "R9", {tag, " ready with frame_done"}, int'(in_ready), 1);
        chk(exp_q.size() == 0, "R7", {tag, " bits left unconsumed"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
        chk(frame_done == 1'b0, "R1", "reset frame_done", int'(frame_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && !out_valid, "R1", "after reset release", int'(in_ready), 1);
        run_frame(0, 0, 0, "R5 zeros");
        run_frame(3, 0, 0, "R5 random");
        run_frame(3, 23, 0, "R6 R3 random+errors");
        run_frame(1, 21, 3, "R2 R6 ones+gaps+errors");
        run_frame(2, 0, 5, "R2 alternating+gaps");
        run_frame(3, 20, 0, "R3 R6 random+dense errors");
        repeat (5) @(negedge clk);
        chk(!out_valid, "R7", "no output after frames", int'(out_valid), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule